// File: doc/BRIEF.md
# Chunk Address Remapper with Lock-Triggered Reshuffle

This block keeps the logical-to-physical placement of one chunk of memory blocks so that the addresses a cache sends off-chip do not reveal repeating access patterns. Each logical block index in the chunk maps to a physical slot in the same chunk. Cache traffic is reported to the block as events, and each event names one logical block. A refill from memory or a store into a block marks that block as locked. When a locked block is evicted, the block starts a fresh random reshuffle of the entire chunk.

The reshuffle is a sequential Fisher–Yates pass. It runs from the top logical index down to index 1, and each cycle it swaps the slot of the current index with the slot of a randomly chosen index at or below it. A Galois LFSR supplies the random bits. For every swap that moves data, the block publishes both logical indices and their current physical slots. A relocation engine outside the block reads the two slots and writes each block into the other's slot. When the pass finishes, every lock bit in the chunk is cleared. While the pass runs, the block reports busy, refuses translations and ignores events.

Top module: `chunk_remapper`

## Requirements
- R1: After reset the mapping is the identity (logical index i sits in physical slot i), busy is low and no relocation is offered.
- R2: While idle, tr_ready is high and tr_slot shows the current physical slot of tr_idx in the same cycle. During a reshuffle, tr_ready is low.
- R3: A fill event (ev_kind = 0) locks the named block. A later evict event (ev_kind = 2) of that block raises busy on the cycle after the event is accepted.
- R4: A write event (ev_kind = 1) locks the named block. One write or several writes have the same effect, and a later eviction of the block starts a reshuffle.
- R5: Evicting a block that is not locked leaves busy low and leaves the mapping unchanged.
- R6: A reshuffle keeps busy high for exactly NBLK-1 cycles. In the k-th of those cycles (counting from 0), rl_idx_a equals NBLK-1-k. When rl_valid is high, rl_idx_b is strictly smaller than rl_idx_a, and rl_valid is never high outside a reshuffle.
- R7: When rl_valid is high, rl_slot_a and rl_slot_b are the current slots of rl_idx_a and rl_idx_b, and the two slots are exchanged at the end of that cycle. The mapping stays a permutation of the slots at all times.
- R8: At the end of a reshuffle all lock bits of the chunk are cleared, so evicting any previously locked block does not start another reshuffle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Cache event present |
| ev_kind | input | 2 | 0 fill, 1 write, 2 evict, 3 none |
| ev_idx | input | IW | Logical block index of the event |
| tr_idx | input | IW | Logical block index to translate |
| tr_slot | output | IW | Physical slot of tr_idx |
| tr_ready | output | 1 | Translation valid (not reshuffling) |
| busy | output | 1 | Reshuffle in progress |
| rl_valid | output | 1 | Relocation swap offered this cycle |
| rl_idx_a | output | IW | Upper logical index of the swap step |
| rl_idx_b | output | IW | Randomly picked lower logical index |
| rl_slot_a | output | IW | Current slot of rl_idx_a |
| rl_slot_b | output | IW | Current slot of rl_idx_b |

## Verification
If the lock state is wrong, the first eviction that follows shows it: busy rises when it should stay low, or stays low when it should rise, on the cycle right after the evict is accepted. If the remap table is corrupted, rl_slot_a or rl_slot_b at the next swap no longer matches a mapping rebuilt from the published swaps. The full sweep of translations after each reshuffle also exposes it within one pass. A fault in the step counter appears within one reshuffle, as a wrong rl_idx_a sequence or a busy window of the wrong length.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    EV_FILL  = 2'd0,
    EV_WRITE = 2'd1,
    EV_EVICT = 2'd2,
    EV_NONE  = 2'd3
  } ev_kind_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_PERM = 1'b1
  } seq_state_e;
endpackage

// File: rtl/remap_lfsr.sv
module remap_lfsr #(
  parameter int          LW   = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [LW-1:0] state
);
  logic [LW-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (adv) st_d = {1'b0, st_q[LW-1:1]} ^ (st_q[0] ? TAPS[LW-1:0] : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED[LW-1:0];
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/remap_table.sv
module remap_table #(
  parameter int NBLK = 16,
  localparam int IW  = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap_en,
  input  logic [IW-1:0] swap_a,
  input  logic [IW-1:0] swap_b,
  input  logic [IW-1:0] rd_idx,
  output logic [IW-1:0] rd_slot,
  output logic [IW-1:0] slot_a,
  output logic [IW-1:0] slot_b
);
  logic [IW-1:0] map_q [NBLK];
  logic [IW-1:0] map_d [NBLK];

  always_comb begin
    for (int k = 0; k < NBLK; k++) map_d[k] = map_q[k];
    if (swap_en) begin
      map_d[swap_a] = map_q[swap_b];
      map_d[swap_b] = map_q[swap_a];
    end
  end

  generate
    for (genvar g = 0; g < NBLK; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       map_q[g] <= IW'(g);
        else if (swap_en) map_q[g] <= map_d[g];
      end
    end
  endgenerate

  assign rd_slot = map_q[rd_idx];
  assign slot_a  = map_q[swap_a];
  assign slot_b  = map_q[swap_b];

  logic [NBLK-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < NBLK; k++) seen[map_q[k]] = 1'b1;
  end

  // R7
  bijection_chk: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);
endmodule

// File: rtl/remap_locks.sv
module remap_locks #(
  parameter int NBLK = 16,
  localparam int IW  = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_all,
  input  logic [IW-1:0] chk_idx,
  output logic          chk_locked
);
  logic [NBLK-1:0] lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (clr_all) lock_d = '0;
    if (set_en)  lock_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lock_q <= '0;
    else if (set_en || clr_all) lock_q <= lock_d;
  end

  assign chk_locked = lock_q[chk_idx];

  // R3
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> lock_q[$past(set_idx)]);
  // R8
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !set_en) |=> (lock_q == '0));
endmodule

// File: rtl/remap_seq.sv
module remap_seq #(
  parameter int NBLK = 16,
  parameter int RW   = 8,
  localparam int IW  = $clog2(NBLK),
  localparam int PW  = RW + IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] rnd,
  output logic          busy,
  output logic          last,
  output logic [IW-1:0] step,
  output logic [IW-1:0] pick
);
  import remap_pkg::*;

  seq_state_e    st_q, st_d;
  logic [IW-1:0] step_q, step_d;
  logic [PW-1:0] prod;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    case (st_q)
      SQ_IDLE: if (start) begin
        st_d   = SQ_PERM;
        step_d = IW'(NBLK - 1);
      end
      SQ_PERM: begin
        if (step_q == IW'(1)) st_d = SQ_IDLE;
        else                  step_d = step_q - IW'(1);
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  // scaled random pick in 0..step: (rnd * (step+1)) >> RW
  always_comb prod = PW'(rnd) * (PW'(step_q) + PW'(1));

  assign busy = (st_q == SQ_PERM);
  assign last = busy && (step_q == IW'(1));
  assign step = step_q;
  assign pick = IW'(prod >> RW);

  // R6
  pick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pick <= step_q));
  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_q != IW'(1)) |=> (busy && step_q == $past(step_q) - IW'(1)));
  // R6
  step_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (step_q == IW'(NBLK - 1)));
endmodule

// File: rtl/chunk_remapper.sv
module chunk_remapper #(
  parameter int          NBLK = 16,
  parameter int          RW   = 8,
  parameter int          LW   = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int         IW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [1:0]    ev_kind,
  input  logic [IW-1:0] ev_idx,
  input  logic [IW-1:0] tr_idx,
  output logic [IW-1:0] tr_slot,
  output logic          tr_ready,
  output logic          busy,
  output logic          rl_valid,
  output logic [IW-1:0] rl_idx_a,
  output logic [IW-1:0] rl_idx_b,
  output logic [IW-1:0] rl_slot_a,
  output logic [IW-1:0] rl_slot_b
);
  import remap_pkg::*;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  logic rst_i_n;
  assign rst_i_n = rsync_q[1];

  ev_kind_e      kind;
  logic          accept, set_en, start, locked, last;
  logic [IW-1:0] step, pick;
  logic [LW-1:0] rnd_state;

  assign kind   = ev_kind_e'(ev_kind);
  assign accept = ev_valid && !busy;
  assign set_en = accept && (kind == EV_FILL || kind == EV_WRITE);
  assign start  = accept && (kind == EV_EVICT) && locked;

  // LFSR runs every cycle so the swap choices also depend on idle timing
  remap_lfsr #(.LW(LW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_i_n), .adv(1'b1), .state(rnd_state)
  );

  remap_seq #(.NBLK(NBLK), .RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .rnd(rnd_state[RW-1:0]),
    .busy(busy), .last(last), .step(step), .pick(pick)
  );

  remap_locks #(.NBLK(NBLK)) u_locks (
    .clk(clk), .rst_n(rst_i_n), .set_en(set_en), .set_idx(ev_idx),
    .clr_all(last), .chk_idx(ev_idx), .chk_locked(locked)
  );

  remap_table #(.NBLK(NBLK)) u_tab (
    .clk(clk), .rst_n(rst_i_n), .swap_en(busy), .swap_a(step), .swap_b(pick),
    .rd_idx(tr_idx), .rd_slot(tr_slot), .slot_a(rl_slot_a), .slot_b(rl_slot_b)
  );

  assign tr_ready = !busy;
  assign rl_valid = busy && (pick != step);
  assign rl_idx_a = step;
  assign rl_idx_b = pick;

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    start |=> busy);
  // R6
  rl_in_perm_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rl_valid |-> busy);
  // R5
  no_start_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && kind == EV_EVICT && !locked) |=> !busy);
endmodule

// File: tb/tb_chunk_remapper.sv
module tb_chunk_remapper;
  localparam int NBLK = 16;
  localparam int IW   = $clog2(NBLK);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ev_valid;
  logic [1:0]    ev_kind;
  logic [IW-1:0] ev_idx, tr_idx;
  logic [IW-1:0] tr_slot, rl_idx_a, rl_idx_b, rl_slot_a, rl_slot_b;
  logic          tr_ready, busy, rl_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int model [NBLK];

  always #2 clk = ~clk;

  chunk_remapper #(.NBLK(NBLK)) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_idx(ev_idx), .tr_idx(tr_idx), .tr_slot(tr_slot), .tr_ready(tr_ready),
    .busy(busy), .rl_valid(rl_valid), .rl_idx_a(rl_idx_a), .rl_idx_b(rl_idx_b),
    .rl_slot_a(rl_slot_a), .rl_slot_b(rl_slot_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_map(input string req);
    bit [NBLK-1:0] seen = '0;
    for (int i = 0; i < NBLK; i++) begin
      tr_idx = IW'(i);
      #0.1;
      check(tr_slot == IW'(model[i]), req, int'(tr_slot), model[i]);
      seen[tr_slot] = 1'b1;
    end
    check(&seen, "R7 bijection", int'(seen), (1 << NBLK) - 1);
  endtask

  // drive one event; returns at the negedge after it was sampled
  task automatic send(input int kind, input int idx);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 2'(kind); ev_idx = IW'(idx);
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 2'd3;
  endtask

  task automatic evict(input int idx, input bit exp_perm, input string req);
    int k;
    int a, b, t;
    send(2, idx);
    check(busy == exp_perm, req, int'(busy), int'(exp_perm));
    k = 0;
    while (busy && k < NBLK + 4) begin
      check(tr_ready == 1'b0, "R2 stall while busy", int'(tr_ready), 0);
      check(rl_idx_a == IW'(NBLK - 1 - k), "R6 step order", int'(rl_idx_a), NBLK - 1 - k);
      if (rl_valid) begin
        a = int'(rl_idx_a); b = int'(rl_idx_b);
        check(b < a, "R6 lower pick", b, a - 1);
        check(rl_slot_a == IW'(model[a]), "R7 slot a", int'(rl_slot_a), model[a]);
        check(rl_slot_b == IW'(model[b]), "R7 slot b", int'(rl_slot_b), model[b]);
        t = model[a]; model[a] = model[b]; model[b] = t;
      end
      k++;
      @(negedge clk);
    end
    if (exp_perm) check(k == NBLK - 1, "R6 busy length", k, NBLK - 1);
    check(tr_ready == 1'b1, "R2 ready when idle", int'(tr_ready), 1);
    check_map(exp_perm ? "R7 mapping after reshuffle" : "R5 mapping unchanged");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_kind = 2'd3; ev_idx = '0; tr_idx = '0;
    for (int i = 0; i < NBLK; i++) model[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(rl_valid == 1'b0, "R1 rl_valid", int'(rl_valid), 0);
    check(tr_ready == 1'b1, "R2 ready", int'(tr_ready), 1);
    check_map("R1 identity");

    // R5 evicting unlocked blocks
    for (int i = 0; i < NBLK; i++) evict(i, 1'b0, "R5 unlocked evict");

    // R3 fill locks; R8 lock gone after reshuffle
    for (int i = 0; i < NBLK; i++) begin
      send(0, i);
      evict((i + 1) % NBLK, 1'b0, "R5 other block unlocked");
      evict(i, 1'b1, "R3 fill then evict");
      evict(i, 1'b0, "R8 lock cleared");
    end

    // R4 write locks (single and repeated)
    for (int i = 0; i < NBLK; i++) begin
      send(1, i);
      if (i % 2 == 1) send(1, i);
      evict(i, 1'b1, "R4 write then evict");
    end

    // R8 whole chunk unlocked after one reshuffle
    for (int i = 0; i < NBLK; i++) send(0, i);
    evict(5, 1'b1, "R3 fill all then evict");
    for (int i = 0; i < NBLK; i++) evict(i, 1'b0, "R8 all locks cleared");

    // R4 mixed fill and write locks
    send(1, 3); send(0, 9);
    evict(9, 1'b1, "R3 fill lock among writes");
    evict(3, 1'b0, "R8 write lock cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule